// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

A target device that loses power or is reset in the middle of a byte can keep SDA low for good. While it does, no controller can issue a START. This block frees such a bus. On a start pulse it takes over the two open-drain lines and holds the companion controller core in soft reset. It also gives one pulse to clear that core's sticky status. It then reads the synchronized bus. If both lines are already high, it finishes at once. Otherwise it releases both lines and waits one phase time. It then runs a loop. Each step first samples the bus and ends as soon as the bus reads free. If the bus is not free, the step pulls SCL low for one phase time and releases it for one phase time. The stuck target receives the clocks it is waiting for and lets SDA go.

The number of clock pulses is capped. If the cap is reached while the bus is still not free, the block ends with a failure flag. The phase time is set as a count of system clocks, so the same block serves any clock frequency. The default is 500 clocks, which is 10 µs at 50 MHz. Both line drivers are drive-low enables, so a high level is never driven actively. Sending a STOP after recovery is left to the controller core.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, no line is driven low and `busy`, `done`, `fail`, `hold_core` and `status_clr` are all 0.
- R2: If both synchronized lines read high when a start is accepted, `done` rises on the second clock edge after the start edge, with `fail` at 0 and no SCL pulse.
- R3: `sda_pull` is never asserted; SDA is only ever released.
- R4: Each SCL low phase lasts exactly `PHASE_CLKS` clocks and is followed by a release of `PHASE_CLKS` clocks before the next bus sample.
- R5: Recovery stops at the first sample that reads the bus free, so a target that needs k SCL pulses, with k no larger than `MAX_PULSES`, gets exactly k pulses and `fail` stays 0.
- R6: At most `MAX_PULSES` SCL pulses are issued per run. If the bus is still not free after the last of them, `fail` is 1 together with `done`, and `fail` holds until the next accepted start.
- R7: `hold_core` is 1 for every cycle `busy` is 1, and `status_clr` is a single-cycle pulse on each accepted start.
- R8: A start that arrives while `busy` is 1 is ignored and does not change the pulse count of the run in progress.
- R9: `done` is a one-cycle pulse per run, and `busy` falls on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a recovery run (taken only when idle) |
| scl_in | input | 1 | Raw level read from the SCL wire |
| sda_in | input | 1 | Raw level read from the SDA wire |
| scl_pull | output | 1 | Drive-low enable for SCL |
| sda_pull | output | 1 | Drive-low enable for SDA (kept released) |
| hold_core | output | 1 | Holds the controller core in soft reset during a run |
| status_clr | output | 1 | One-cycle pulse that clears the core's sticky status |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Last run ended with the bus still stuck |

## Verification
The assertions assume that `PHASE_CLKS` is at least 3, so that a released SCL passes the two-flop synchronizer before the next sample. They also assume that the raw line inputs do not change within a single cycle. The bench models a target that keeps SDA low until it has seen a random number of SCL pulses, and sometimes a target that holds SCL low for good. It applies each start only after the line levels have settled through the synchronizer. It drives every input at the falling clock edge, so every line change is a clean single-cycle level.

// File: rtl/i2c_unstick_pkg.sv
// Shared definitions for the bus-stuck recovery sequencer.
package i2c_unstick_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_PROBE  = 3'd3,
        ST_LOW    = 3'd4,
        ST_HIGH   = 3'd5,
        ST_FINISH = 3'd6
    } rcv_state_t;
endpackage

// File: rtl/unstick_sync.sv
// Multi-stage synchronizer for the raw bus levels.
// Assumes: inputs are asynchronous levels; reset value is 1 (idle bus high).
module unstick_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift each bit through its own flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw[b]};
            end
            assign synced[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/unstick_timer.sv
// Phase timer: after a load, expired goes high PHASE_CLKS cycles later.
// Assumes: PHASE_CLKS >= 1; it holds at zero until the next load.
module unstick_timer #(
    parameter int PHASE_CLKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int TW = $clog2(PHASE_CLKS + 1);
    logic [TW-1:0] cnt;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= TW'(PHASE_CLKS - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(PHASE_CLKS - 1)); // R4
endmodule

// File: rtl/unstick_fsm.sv
// Recovery control: bus check, settle, probe/pulse loop with a pulse budget.
// Assumes: bus_free comes from synchronized lines; PHASE_CLKS >= 3.
module unstick_fsm
    import i2c_unstick_pkg::*;
#(
    parameter int MAX_PULSES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_free,
    input  logic phase_done,
    output logic phase_load,
    output logic scl_pull,
    output logic busy,
    output logic done,
    output logic fail,
    output logic status_clr
);
    localparam int PW = $clog2(MAX_PULSES + 1);

    rcv_state_t     state, nxt;
    logic [PW-1:0]  pulses;
    logic           fail_q;
    logic           accept;

    assign accept = (state == ST_IDLE) && start;

    // Next-state and phase-timer load decisions.
    always_comb begin
        nxt        = state;
        phase_load = 1'b0;
        case (state)
            ST_IDLE:   if (start) nxt = ST_CHECK;
            ST_CHECK:  begin
                if (bus_free) nxt = ST_FINISH;
                else begin nxt = ST_SETTLE; phase_load = 1'b1; end
            end
            ST_SETTLE: if (phase_done) nxt = ST_PROBE;
            ST_PROBE:  begin
                if (bus_free || pulses == PW'(MAX_PULSES)) nxt = ST_FINISH;
                else begin nxt = ST_LOW; phase_load = 1'b1; end
            end
            ST_LOW:    if (phase_done) begin nxt = ST_HIGH; phase_load = 1'b1; end
            ST_HIGH:   if (phase_done) nxt = ST_PROBE;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Pulse budget counter: cleared per run, bumped on each low phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pulses <= '0;
        else if (accept)                              pulses <= '0;
        else if (state == ST_PROBE && nxt == ST_LOW)  pulses <= pulses + 1'b1;
    end

    // Failure flag: set when the budget runs out, cleared by the next run.
    always_ff @(posedge clk) begin
        if (!rst_n)      fail_q <= 1'b0;
        else if (accept) fail_q <= 1'b0;
        else if (state == ST_PROBE && !bus_free && pulses == PW'(MAX_PULSES))
                         fail_q <= 1'b1;
    end

    assign scl_pull   = (state == ST_LOW);
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_FINISH);
    assign fail       = fail_q;
    assign status_clr = accept;

    AST_BUDGET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PW'(MAX_PULSES)); // R6
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> done); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9
    AST_CLR_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (busy && !status_clr)); // R7
    AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> (busy && !done)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != ST_PROBE) |=> $stable(pulses)); // R8
endmodule

// File: rtl/i2c_unstick.sv
// Top of the bus-stuck recovery sequencer: synchronizer, phase timer, control.
// Assumes: scl_in/sda_in are raw wire levels; outputs drive open-drain pads
// as pull-low enables only; PHASE_CLKS >= 3 clocks.
module i2c_unstick #(
    parameter int PHASE_CLKS = 500,
    parameter int MAX_PULSES = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_pull,
    output logic sda_pull,
    output logic hold_core,
    output logic status_clr,
    output logic busy,
    output logic done,
    output logic fail
);
    logic [1:0] line_sync;
    logic       bus_free;
    logic       phase_load;
    logic       phase_done;

    unstick_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(line_sync)
    );

    // Free only when both synchronized lines read high.
    assign bus_free = line_sync[1] & line_sync[0];

    unstick_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(phase_load), .expired(phase_done)
    );

    unstick_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_free(bus_free),
        .phase_done(phase_done), .phase_load(phase_load), .scl_pull(scl_pull),
        .busy(busy), .done(done), .fail(fail), .status_clr(status_clr)
    );

    assign sda_pull  = 1'b0;
    assign hold_core = busy;
endmodule

// File: tb/sim_i2c_unstick.sv
// Bench: target model that holds SDA low for a set number of SCL pulses.
module sim_i2c_unstick;
    localparam int PH  = 4;
    localparam int MAX = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_pull, sda_pull, hold_core, status_clr, busy, done, fail;

    int  need = 0;
    logic scl_stuck = 1'b0;
    logic clr_obs = 1'b0;

    int  seen_pulses = 0, low_run = 0, low_min = 0, low_max = 0;
    int  done_cnt = 0, clr_cnt = 0, hold_bad = 0, sda_bad = 0;
    logic prev_pull = 1'b0;
    int  errors = 0, checks = 0;
    logic hung = 1'b0;

    logic tgt_sda_low, scl_line, sda_line;
    assign tgt_sda_low = (seen_pulses < need);
    assign scl_line = !(scl_pull || scl_stuck);
    assign sda_line = !(sda_pull || tgt_sda_low);

    always #10 clk = ~clk;

    i2c_unstick #(.PHASE_CLKS(PH), .MAX_PULSES(MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .scl_in(scl_line),
        .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .hold_core(hold_core), .status_clr(status_clr), .busy(busy),
        .done(done), .fail(fail)
    );

    // Observers: pulse count, low widths, done/clear counts, invariants.
    always @(posedge clk) begin
        if (clr_obs) begin
            seen_pulses <= 0; low_run <= 0; low_min <= 1000; low_max <= 0;
            done_cnt <= 0; clr_cnt <= 0; hold_bad <= 0; sda_bad <= 0;
        end else begin
            if (scl_pull && !prev_pull) seen_pulses <= seen_pulses + 1;
            if (scl_pull) low_run <= low_run + 1;
            else if (prev_pull) begin
                if (low_run < low_min) low_min <= low_run;
                if (low_run > low_max) low_max <= low_run;
                low_run <= 0;
            end
            if (done) done_cnt <= done_cnt + 1;
            if (status_clr) clr_cnt <= clr_cnt + 1;
            if (hold_core != busy) hold_bad <= hold_bad + 1;
            if (sda_pull) sda_bad <= sda_bad + 1;
        end
        prev_pull <= scl_pull;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k, input logic stuck);
        if (stuck || k > MAX) return MAX;
        return k;
    endfunction

    function automatic int exp_fail(input int k, input logic stuck);
        return (stuck || k > MAX) ? 1 : 0;
    endfunction

    // One recovery run: set up target, settle, start, wait for done, check.
    task automatic run(input int k, input logic stuck, input logic extra_start);
        @(negedge clk) clr_obs = 1'b1;
        @(negedge clk) begin clr_obs = 1'b0; need = k; scl_stuck = stuck; end
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (k == 0 && !stuck) begin
            @(negedge clk);
            chk("R2 done on second edge", int'(done), 1);
            chk("R2 no fail", int'(fail), 0);
        end
        for (int i = 0; i < 2000 && !done; i++) begin
            if (extra_start && i == 3) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        if (!done) begin hung = 1'b1; chk("R9 done reached", 0, 1); end
        chk("R6 fail with done", int'(fail), exp_fail(k, stuck));
        @(negedge clk);
        chk("R9 busy falls after done", int'(busy), 0);
        chk(extra_start ? "R8 pulses unchanged" : "R5 pulse count",
            seen_pulses, exp_pulses(k, stuck));
        chk("R9 one done", done_cnt, 1);
        chk("R7 one status clear", clr_cnt, 1);
        chk("R7 hold tracks busy", hold_bad, 0);
        chk("R3 sda never pulled", sda_bad, 0);
        chk("R6 fail held after run", int'(fail), exp_fail(k, stuck));
        if (seen_pulses > 0) begin
            chk("R4 min low width", low_min, PH);
            chk("R4 max low width", low_max, PH);
        end else begin
            chk("R2 no scl pulse", int'(scl_pull), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 scl released", int'(scl_pull), 0);
        chk("R1 busy low", int'(busy), 0);
        chk("R1 done/fail low", int'(done | fail), 0);
        chk("R1 hold/clear low", int'(hold_core | status_clr), 0);
        rst_n = 1'b1;
        run(0, 1'b0, 1'b0);          // R2 free bus
        run(1, 1'b0, 1'b0);          // R5 one pulse
        run(MAX, 1'b0, 1'b0);        // R5 exactly at budget
        run(MAX + 1, 1'b0, 1'b0);    // R6 just over budget
        run(0, 1'b1, 1'b0);          // R6 SCL held low
        run(3, 1'b0, 1'b1);          // R8 start while busy
        for (int t = 0; t < 20 && !hung; t++)
            run(int'($urandom_range(0, MAX + 2)), ($urandom_range(0, 4) == 0), 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule